// File: doc/BRIEF.md
# Byte Register File with Indirect Macro Window

This block is the byte-wide register file that sits behind a serial slave's address and data strobes. Each bus cycle carries one address byte together with a write pulse, a read pulse, or both. Local registers hold the board-level controls: an LED drive, an enable for the chain output, a reset for the macro clock domain, and a 7-bit device address for daisy-chained parts. The block also holds a 32-bit free-running performance counter, a fixed chip identifier and a fixed macro identifier.

Several hashing macros sit behind an indirect window. Software first stores a macro register address and a data byte, then chooses macros with a bit-mapped select mask. A write to the strobe address sends a one-cycle write strobe to every selected macro. A control-byte write with bit 0 set sends a one-cycle read strobe, and the selected macros' bytes are captured for a later read.

At some addresses a read and a write reach different registers.

Top module: `winreg_bank`

## Requirements
- R1: Synchronous active-high reset clears every stored register, the captured window byte, the counter, its snapshot, both strobe vectors and `bus_rdata`.
- R2: Address 0x00 is the macro register address. It is readable and writable and drives `mac_addr`.
- R3: Address 0x01 holds the macro write data. It is write-only, reads as 0x00, and drives `mac_wdata`.
- R4: At address 0x02, a read returns the macro interrupt inputs zero-extended to a byte (bit i is macro i). A write stores the select mask from the low `NUM_MACROS` bits. The mask is not readable.
- R5: Writing the control byte at 0x03 stores the following bits. Bit 2 is the counter enable. Bit 3 drives `led_o`. Bit 4 drives `mac_clk_rst_o`. Bit 5 drives `chain_en_o`. A read returns these four bits in the same positions, and bits 0, 1, 6 and 7 read as zero.
- R6: Address 0x04 holds a 7-bit device address. It drives `dev_addr_o`, and bit 7 reads as zero.
- R7: A read of 0x05 returns `CHIP_ID`. A write to 0x05 raises `mac_wr_stb` equal to the select mask for exactly the one cycle after the write edge.
- R8: A read of 0x06 returns `UNIT_ID`.
- R9: A control write with bit 0 set raises `mac_rd_stb` equal to the select mask for exactly one cycle. At the end of that cycle the bitwise OR of the selected macros' `mac_rdata` bytes is captured, and 0x80 returns the captured byte. An empty mask raises no strobe and leaves the captured byte unchanged.
- R10: The 32-bit counter adds one on every clock edge at which the enable bit is set and holds otherwise. Its value wraps.
- R11: A read of 0x07 returns counter bits 7:0 and, at the same edge, snapshots bits 31:8. Reads of 0x08, 0x09 and 0x0A return bytes 1, 2 and 3 of that snapshot.
- R12: Unmapped addresses read as 0x00. Writes to 0x06, 0x07 to 0x0A and 0x80 change nothing that can be read back.
- R13: `bus_rdata` is loaded at the edge where `bus_rd` is high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write pulse for the current address |
| bus_rd | input | 1 | Read pulse for the current address |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mac_addr | output | 8 | Macro register address carried with strobes |
| mac_wdata | output | 8 | Macro write byte carried with strobes |
| mac_wr_stb | output | NUM_MACROS | Per-macro write strobe |
| mac_rd_stb | output | NUM_MACROS | Per-macro read strobe |
| mac_rdata | input | 8*NUM_MACROS | Byte returned by each macro |
| mac_irq | input | NUM_MACROS | Per-macro interrupt |
| led_o | output | 1 | LED drive |
| mac_clk_rst_o | output | 1 | Macro clock-domain reset |
| chain_en_o | output | 1 | Chain output enable |
| dev_addr_o | output | 7 | Device address for chaining |

## Verification
Each result arrives a fixed number of cycles after its stimulus. Read data appears one edge after the read pulse. Stored controls and the macro address and data outputs change at the write edge itself. A strobe is high during the cycle that follows its write edge. The captured window byte becomes readable from the second edge after the control write. The bench drives inputs on the falling edge and samples one time unit after the rising edge at which each result is due. After every write it checks that the strobes have returned to zero one cycle later. To predict the counter, the bench keeps its own count of the edges at which the enable was set, and it takes the value due for a 0x07 read before that read's edge.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    localparam logic [7:0] A_MADDR = 8'h00;
    localparam logic [7:0] A_MDATA = 8'h01;
    localparam logic [7:0] A_MSEL  = 8'h02;
    localparam logic [7:0] A_CTRL  = 8'h03;
    localparam logic [7:0] A_DEVAD = 8'h04;
    localparam logic [7:0] A_IDSTB = 8'h05;
    localparam logic [7:0] A_UID   = 8'h06;
    localparam logic [7:0] A_PC0   = 8'h07;
    localparam logic [7:0] A_PC1   = 8'h08;
    localparam logic [7:0] A_PC2   = 8'h09;
    localparam logic [7:0] A_PC3   = 8'h0A;
    localparam logic [7:0] A_WIN   = 8'h80;

    localparam int CNT_W = 32;

    typedef struct packed {
        logic chain_en;
        logic mclk_rst;
        logic led;
        logic cnt_en;
    } ctrl_t;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] addr;
        logic [7:0] data;
    } bus_t;

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.chain_en = b[5];
        c.mclk_rst = b[4];
        c.led      = b[3];
        c.cnt_en   = b[2];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        return {2'b00, c.chain_en, c.mclk_rst, c.led, c.cnt_en, 2'b00};
    endfunction

endpackage

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NM = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_t          bus,
    output logic [7:0]    maddr,
    output logic [7:0]    mwdata,
    output logic [NM-1:0] sel,
    output ctrl_t         ctl,
    output logic [6:0]    devaddr,
    output logic          wr_evt,
    output logic          rd_evt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            maddr   <= '0;
            mwdata  <= '0;
            sel     <= '0;
            ctl     <= '0;
            devaddr <= '0;
        end else if (bus.wr) begin
            case (bus.addr)
                A_MADDR: maddr   <= bus.data;
                A_MDATA: mwdata  <= bus.data;
                A_MSEL:  sel     <= bus.data[NM-1:0];
                A_CTRL:  ctl     <= ctrl_from_byte(bus.data);
                A_DEVAD: devaddr <= bus.data[6:0];
                default: ;
            endcase
        end
    end

    assign wr_evt = bus.wr && (bus.addr == A_IDSTB);
    assign rd_evt = bus.wr && (bus.addr == A_CTRL) && bus.data[0];

    p_led_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (bus.wr && bus.addr == A_CTRL) |=> (ctl.led == $past(bus.data[3])));

    p_maddr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus.wr && bus.addr == A_MADDR) |=> $stable(maddr));

endmodule

// File: rtl/winreg_window.sv
module winreg_window #(
    parameter int NM = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NM-1:0]   sel,
    input  logic            wr_evt,
    input  logic            rd_evt,
    input  logic [8*NM-1:0] mac_rdata,
    output logic [NM-1:0]   mac_wr_stb,
    output logic [NM-1:0]   mac_rd_stb,
    output logic [7:0]      win_q
);

    logic [7:0] masked [NM];
    logic [7:0] merged;

    for (genvar i = 0; i < NM; i++) begin : g_mask
        assign masked[i] = mac_rdata[i*8 +: 8] & {8{mac_rd_stb[i]}};
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < NM; i++) merged = merged | masked[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mac_wr_stb <= '0;
            mac_rd_stb <= '0;
            win_q      <= '0;
        end else begin
            mac_wr_stb <= wr_evt ? sel : '0;
            mac_rd_stb <= rd_evt ? sel : '0;
            if (|mac_rd_stb) win_q <= merged;
        end
    end

    p_wr_stb_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (|mac_wr_stb) |-> $past(wr_evt));

    p_rd_stb_subset_r9: assert property (@(posedge clk) disable iff (rst)
        ((mac_rd_stb & ~sel) == '0));

    p_win_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(|mac_rd_stb) |=> $stable(win_q));

endmodule

// File: rtl/winreg_perf.sv
module winreg_perf
    import winreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             take_snap,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-9:0] snap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            snap <= '0;
        end else begin
            if (en) cnt <= cnt + 1'b1;
            if (take_snap) snap <= cnt[CNT_W-1:8];
        end
    end

    p_cnt_inc_r10: assert property (@(posedge clk) disable iff (rst)
        en |=> (cnt == $past(cnt) + 1'b1));

    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    p_snap_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !take_snap |=> $stable(snap));

endmodule

// File: rtl/winreg_bank.sv
module winreg_bank
    import winreg_pkg::*;
#(
    parameter int         NUM_MACROS = 4,
    parameter logic [7:0] CHIP_ID    = 8'hA5,
    parameter logic [7:0] UNIT_ID    = 8'h3C
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [7:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output logic [7:0]              mac_addr,
    output logic [7:0]              mac_wdata,
    output logic [NUM_MACROS-1:0]   mac_wr_stb,
    output logic [NUM_MACROS-1:0]   mac_rd_stb,
    input  logic [8*NUM_MACROS-1:0] mac_rdata,
    input  logic [NUM_MACROS-1:0]   mac_irq,
    output logic                    led_o,
    output logic                    mac_clk_rst_o,
    output logic                    chain_en_o,
    output logic [6:0]              dev_addr_o
);

    bus_t                  bus;
    logic [NUM_MACROS-1:0] sel;
    ctrl_t                 ctl;
    logic                  wr_evt;
    logic                  rd_evt;
    logic [7:0]            win_q;
    logic [CNT_W-1:0]      cnt;
    logic [CNT_W-9:0]      snap;
    logic [7:0]            irq8;
    logic [7:0]            rd_mux;

    assign bus = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, data: bus_wdata};

    winreg_ctrl #(.NM(NUM_MACROS)) u_ctrl (
        .clk(clk), .rst(rst), .bus(bus),
        .maddr(mac_addr), .mwdata(mac_wdata), .sel(sel), .ctl(ctl),
        .devaddr(dev_addr_o), .wr_evt(wr_evt), .rd_evt(rd_evt)
    );

    winreg_window #(.NM(NUM_MACROS)) u_window (
        .clk(clk), .rst(rst), .sel(sel), .wr_evt(wr_evt), .rd_evt(rd_evt),
        .mac_rdata(mac_rdata), .mac_wr_stb(mac_wr_stb),
        .mac_rd_stb(mac_rd_stb), .win_q(win_q)
    );

    winreg_perf u_perf (
        .clk(clk), .rst(rst), .en(ctl.cnt_en),
        .take_snap(bus_rd && bus_addr == A_PC0),
        .cnt(cnt), .snap(snap)
    );

    assign led_o         = ctl.led;
    assign mac_clk_rst_o = ctl.mclk_rst;
    assign chain_en_o    = ctl.chain_en;

    always_comb begin
        irq8 = '0;
        irq8[NUM_MACROS-1:0] = mac_irq;
    end

    always_comb begin
        case (bus_addr)
            A_MADDR: rd_mux = mac_addr;
            A_MSEL:  rd_mux = irq8;
            A_CTRL:  rd_mux = ctrl_to_byte(ctl);
            A_DEVAD: rd_mux = {1'b0, dev_addr_o};
            A_IDSTB: rd_mux = CHIP_ID;
            A_UID:   rd_mux = UNIT_ID;
            A_PC0:   rd_mux = cnt[7:0];
            A_PC1:   rd_mux = snap[7:0];
            A_PC2:   rd_mux = snap[15:8];
            A_PC3:   rd_mux = snap[23:16];
            A_WIN:   rd_mux = win_q;
            default: rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    p_ctrl_pads_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_CTRL) |=> (bus_rdata[5:2] == {chain_en_o, mac_clk_rst_o, led_o, $past(ctl.cnt_en)}));

    initial begin
        a_nm_range_r4: assert (NUM_MACROS >= 1 && NUM_MACROS <= 8);
    end

endmodule

// File: tb/winreg_bank_bench.sv
module winreg_bank_bench;

    localparam int NM = 4;
    localparam logic [7:0] CID = 8'hA5;
    localparam logic [7:0] UID = 8'h3C;

    logic          clk = 0;
    logic          rst = 1;
    logic          bus_wr = 0, bus_rd = 0;
    logic [7:0]    bus_addr = 0, bus_wdata = 0;
    logic [7:0]    bus_rdata, mac_addr, mac_wdata;
    logic [NM-1:0] mac_wr_stb, mac_rd_stb, mac_irq = 0;
    logic [8*NM-1:0] mac_rdata;
    logic          led_o, mac_clk_rst_o, chain_en_o;
    logic [6:0]    dev_addr_o;

    int n_chk = 0, n_bad = 0;

    // model state
    logic [7:0]    m_maddr = 0, m_wdata = 0, m_ctl = 0, m_win = 0;
    logic [NM-1:0] m_sel = 0;
    logic [6:0]    m_dev = 0;
    logic          m_en = 0;
    logic [31:0]   m_cnt = 0;
    logic [23:0]   m_snap = 0;

    always #10 clk = ~clk;

    winreg_bank #(.NUM_MACROS(NM), .CHIP_ID(CID), .UNIT_ID(UID)) u_winreg_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mac_addr(mac_addr), .mac_wdata(mac_wdata), .mac_wr_stb(mac_wr_stb),
        .mac_rd_stb(mac_rd_stb), .mac_rdata(mac_rdata), .mac_irq(mac_irq),
        .led_o(led_o), .mac_clk_rst_o(mac_clk_rst_o), .chain_en_o(chain_en_o),
        .dev_addr_o(dev_addr_o)
    );

    function automatic logic [7:0] mac_byte(input int i, input logic [7:0] a);
        return a ^ 8'(8'h11 * (i + 1));
    endfunction

    always_comb begin
        for (int i = 0; i < NM; i++) mac_rdata[i*8 +: 8] = mac_byte(i, mac_addr);
    end

    always @(posedge clk) begin
        if (rst) m_cnt <= 0;
        else if (m_en) m_cnt <= m_cnt + 1;
    end

    function automatic logic [7:0] win_expect();
        logic [7:0] v = 0;
        for (int i = 0; i < NM; i++) if (m_sel[i]) v = v | mac_byte(i, m_maddr);
        return v;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_maddr;
            8'h02: return 8'(mac_irq);
            8'h03: return m_ctl;
            8'h04: return {1'b0, m_dev};
            8'h05: return CID;
            8'h06: return UID;
            8'h07: return m_cnt[7:0];
            8'h08: return m_snap[7:0];
            8'h09: return m_snap[15:8];
            8'h0A: return m_snap[23:16];
            8'h80: return m_win;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic do_read(input logic [7:0] a, input string req);
        logic [7:0]  e;
        logic [31:0] c;
        bus_rd = 1; bus_addr = a;
        e = exp_read(a);
        c = m_cnt;
        @(posedge clk); #1;
        if (a == 8'h07) m_snap = c[31:8];
        check(req, bus_rdata, e);
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        logic strobe_rd;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        strobe_rd = (a == 8'h03) && d[0];
        @(posedge clk); #1;
        check("R7", mac_wr_stb, (a == 8'h05) ? m_sel : '0);
        check("R9", mac_rd_stb, strobe_rd ? m_sel : '0);
        case (a)
            8'h00: m_maddr = d;
            8'h01: m_wdata = d;
            8'h02: m_sel = d[NM-1:0];
            8'h03: begin m_ctl = d & 8'h3C; m_en = d[2]; end
            8'h04: m_dev = d[6:0];
            default: ;
        endcase
        if (strobe_rd && m_sel != 0) m_win = win_expect();
        check("R2", mac_addr, m_maddr);
        check("R3", mac_wdata, m_wdata);
        @(negedge clk); bus_wr = 0;
        @(posedge clk); #1;
        check("R7", mac_wr_stb, '0);
        check("R9", mac_rd_stb, '0);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] pick_addr(input logic [31:0] r);
        case (r % 14)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h03;
            4: return 8'h04; 5: return 8'h05; 6: return 8'h06; 7: return 8'h07;
            8: return 8'h08; 9: return 8'h09; 10: return 8'h0A; 11: return 8'h80;
            12: return 8'h0B;
            default: return 8'(r >> 8);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  held;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        check("R1", bus_rdata, 0);
        check("R1", {mac_wr_stb, mac_rd_stb}, 0);
        check("R1", {led_o, mac_clk_rst_o, chain_en_o, dev_addr_o}, 0);
        check("R1", {mac_addr, mac_wdata}, 0);
        do_read(8'h80, "R1");
        do_read(8'h07, "R1");

        // R2 R3 R6 R8 R7 id
        do_write(8'h00, 8'h5A); do_read(8'h00, "R2");
        do_write(8'h01, 8'hC3); do_read(8'h01, "R3");
        do_write(8'h04, 8'hFF); do_read(8'h04, "R6");
        check("R6", dev_addr_o, 7'h7F);
        do_read(8'h05, "R7"); do_read(8'h06, "R8");

        // R4 irq read / select write-only
        mac_irq = 4'b1010; do_read(8'h02, "R4");
        do_write(8'h02, 8'hF5); mac_irq = 4'b0001; do_read(8'h02, "R4");

        // R5 control pads and readback
        do_write(8'h03, 8'hFF);
        check("R5", {chain_en_o, mac_clk_rst_o, led_o}, 3'b111);
        do_read(8'h03, "R5");
        do_write(8'h03, 8'h08);
        check("R5", {chain_en_o, mac_clk_rst_o, led_o}, 3'b001);

        // R7 write strobe with stored mask, R9 read strobe with all/none selected
        do_write(8'h02, 8'h0F); do_write(8'h05, 8'h00);
        do_write(8'h03, 8'h01); do_read(8'h80, "R9");
        do_write(8'h02, 8'h00); do_write(8'h00, 8'h77);
        do_write(8'h03, 8'h01); do_read(8'h80, "R9");

        // R10 enable, count, hold
        do_write(8'h03, 8'h04);
        idle(10); do_read(8'h07, "R10");
        // R11 snapshot differs from live upper bytes
        idle(300);
        do_read(8'h08, "R11"); do_read(8'h09, "R11"); do_read(8'h0A, "R11");
        do_write(8'h03, 8'h00);
        idle(5); do_read(8'h07, "R10"); idle(5); do_read(8'h07, "R10");

        // R12 writes to read-only and unmapped
        do_write(8'h80, 8'hFF); do_read(8'h80, "R12");
        do_write(8'h06, 8'h00); do_read(8'h06, "R12");
        do_write(8'h08, 8'hEE); do_read(8'h08, "R12");
        do_read(8'h0B, "R12"); do_read(8'hFF, "R12");

        // R13 hold between reads
        do_read(8'h05, "R13"); held = bus_rdata;
        idle(4); check("R13", bus_rdata, held);

        // random mix
        for (int k = 0; k < 600; k++) begin
            r = $urandom;
            if (r[31:30] == 2'b00) mac_irq = 4'($urandom);
            if (r[29]) do_write(pick_addr($urandom), 8'($urandom));
            else do_read(pick_addr($urandom), "R12");
            if (r[28:26] == 3'b000) idle(3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule